// File: doc/BRIEF.md
# Multi-Plane Segment Page Address Mapper

This block turns a physical segment number and a page index inside that segment into the absolute page row address of a flash device. On parts with several planes, the pages of one segment do not sit in a single block. Consecutive pages alternate between a pair of adjacent blocks. With four planes, they also alternate between the lower and upper halves of the bank. The mapper steers the low bits of the page index to those places. It then adds the remaining page offset within the block.

Three configuration inputs set the geometry: the plane count, pages per block and blocks per bank. They are sampled together with each request. Requests enter on a valid/ready stream, and each result leaves on a second stream after exactly one register stage. A request is taken on any cycle in which `req_valid` and `req_ready` are both high. `req_ready` is high while the output stage is empty, or while the downstream side takes the current result in the same cycle. This lets a full pipeline move one request per cycle. While `rsp_valid` is high and `rsp_ready` is low, the result holds still and no new request is taken. An unsupported plane count produces an error flag and a zero address instead of a row.

Top module: `seg_page_mapper`

## Requirements
- R1: With a plane count of 1, the row is seg × ppb + pidx.
- R2: With a plane count of 2, the row is 2 × seg × ppb, plus ppb when pidx bit 0 is set, plus pidx shifted right by 1.
- R3: With a plane count of 4, the row is 2 × seg × ppb, plus ppb when pidx bit 0 is set, plus floor(bpb / 2) × ppb when pidx bit 1 is set, plus pidx shifted right by 2.
- R4: The half-bank term uses blocks-per-bank rounded down when halved, so an odd bpb gives floor(bpb / 2) × ppb.
- R5: A plane count other than 1, 2 or 4 (0, 3, 5, 6, 7 on the 3-bit field) returns `rsp_err` = 1 and `rsp_row` = 0. A valid plane count returns `rsp_err` = 0.
- R6: A request accepted at one clock edge shows its result with `rsp_valid` high right after the next edge: one cycle of latency.
- R7: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_row` and `rsp_err` stay unchanged, whatever the request inputs do.
- R8: `req_ready` equals (not `rsp_valid`) or `rsp_ready`. When `rsp_valid` is 1 and `rsp_ready` is 1 in the same cycle without a new request, `rsp_valid` drops to 0.
- R9: After reset, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_seg | input | SEG_W (12) | Physical segment number |
| req_pidx | input | PIDX_W (9) | Page index within the segment |
| cfg_planes | input | 3 | Plane count: 1, 2 or 4 |
| cfg_ppb | input | PPB_W (9) | Pages per block |
| cfg_bpb | input | BPB_W (14) | Blocks per bank |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Downstream takes the result |
| rsp_row | output | ROW_W (24) | Absolute page row address |
| rsp_err | output | 1 | Unsupported plane count |

## Verification
The bench goes after the page-index bits that pick a block and a bank half. It uses every combination of the two low bits in the 2- and 4-plane modes. A mapper that ignored one of them, or used it in the wrong mode, would land pages in the wrong block or the wrong half. An odd blocks-per-bank value exposes any rounding other than floor when the bank is halved. All five invalid plane codes are applied, so a missing or partial error check would leak a nonzero address. Stalls with changing inputs, and drain-and-refill cycles, show whether a mapper drops or overwrites a held result, or serialises to one request every two cycles.

// File: rtl/smap_pkg.sv
package smap_pkg;
  typedef enum logic [1:0] {
    PM_ONE  = 2'd0,
    PM_TWO  = 2'd1,
    PM_FOUR = 2'd2,
    PM_BAD  = 2'd3
  } plane_mode_e;
endpackage

// File: rtl/smap_plane_decode.sv
module smap_plane_decode
  import smap_pkg::*;
(
  input  logic [2:0]  planes,
  output plane_mode_e mode
);
  always_comb begin
    case (planes)
      3'd1:    mode = PM_ONE;
      3'd2:    mode = PM_TWO;
      3'd4:    mode = PM_FOUR;
      default: mode = PM_BAD;
    endcase
  end
endmodule

// File: rtl/smap_addr_calc.sv
module smap_addr_calc
  import smap_pkg::*;
#(
  parameter int SEG_W  = 12,
  parameter int PIDX_W = 9,
  parameter int PPB_W  = 9,
  parameter int BPB_W  = 14,
  parameter int ROW_W  = 24
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [PIDX_W-1:0] pidx,
  input  logic [PPB_W-1:0]  ppb,
  input  logic [BPB_W-1:0]  bpb,
  input  plane_mode_e       mode,
  output logic [ROW_W-1:0]  row,
  output logic              err
);
  logic [ROW_W-1:0] seg_x, ppb_x, half_x, unit;
  logic [ROW_W-1:0] base, blk_off, half_off, intra;

  assign seg_x  = ROW_W'(seg);
  assign ppb_x  = ROW_W'(ppb);
  assign half_x = ROW_W'(bpb >> 1);
  assign unit   = seg_x * ppb_x;

  always_comb begin
    base     = '0;
    blk_off  = '0;
    half_off = '0;
    intra    = '0;
    err      = 1'b0;
    case (mode)
      PM_ONE: begin
        base  = unit;
        intra = ROW_W'(pidx);
      end
      PM_TWO: begin
        base    = unit << 1;
        blk_off = pidx[0] ? ppb_x : '0;
        intra   = ROW_W'(pidx >> 1);
      end
      PM_FOUR: begin
        base     = unit << 1;
        blk_off  = pidx[0] ? ppb_x : '0;
        half_off = pidx[1] ? half_x * ppb_x : '0;
        intra    = ROW_W'(pidx >> 2);
      end
      default: err = 1'b1;
    endcase
  end

  assign row = err ? '0 : base + blk_off + half_off + intra;

  always_comb begin
    if (mode != PM_FOUR)
      AST_NO_HALF_OFFSET: assert (half_off == '0); // R3
  end
endmodule

// File: rtl/smap_out_stage.sv
module smap_out_stage #(
  parameter int ROW_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ROW_W-1:0] d_row,
  input  logic             d_err,
  input  logic             rsp_ready,
  output logic             rsp_valid,
  output logic [ROW_W-1:0] rsp_row,
  output logic             rsp_err,
  output logic             take_ok
);
  assign take_ok = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_row   <= '0;
      rsp_err   <= 1'b0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_row   <= d_row;
      rsp_err   <= d_err;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_row) && $stable(rsp_err)); // R7
  AST_ERR_ZERO_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_row == '0); // R5
  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> rsp_valid); // R6
  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && !load |=> !rsp_valid); // R8
  AST_NO_LOAD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !load); // R7
endmodule

// File: rtl/seg_page_mapper.sv
module seg_page_mapper
  import smap_pkg::*;
#(
  parameter int SEG_W  = 12,
  parameter int PIDX_W = 9,
  parameter int PPB_W  = 9,
  parameter int BPB_W  = 14,
  parameter int ROW_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [PIDX_W-1:0] req_pidx,
  input  logic [2:0]        cfg_planes,
  input  logic [PPB_W-1:0]  cfg_ppb,
  input  logic [BPB_W-1:0]  cfg_bpb,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ROW_W-1:0]  rsp_row,
  output logic              rsp_err
);
  plane_mode_e      mode;
  logic [ROW_W-1:0] calc_row;
  logic             calc_err;
  logic             load;

  smap_plane_decode u_dec (
    .planes (cfg_planes),
    .mode   (mode)
  );

  smap_addr_calc #(
    .SEG_W (SEG_W), .PIDX_W (PIDX_W), .PPB_W (PPB_W),
    .BPB_W (BPB_W), .ROW_W (ROW_W)
  ) u_calc (
    .seg  (req_seg),
    .pidx (req_pidx),
    .ppb  (cfg_ppb),
    .bpb  (cfg_bpb),
    .mode (mode),
    .row  (calc_row),
    .err  (calc_err)
  );

  assign load = req_valid && req_ready;

  smap_out_stage #(.ROW_W (ROW_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .d_row     (calc_row),
    .d_err     (calc_err),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_row   (rsp_row),
    .rsp_err   (rsp_err),
    .take_ok   (req_ready)
  );
endmodule

// File: tb/sim_seg_page_mapper.sv
`timescale 1ns/1ps
module sim_seg_page_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_seg = '0;
  logic [8:0]  req_pidx = '0;
  logic [2:0]  cfg_planes = 3'd1;
  logic [8:0]  cfg_ppb = '0;
  logic [13:0] cfg_bpb = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [23:0] rsp_row;
  logic        rsp_err;

  int n_checks = 0;
  int n_fail = 0;
  bit m_valid = 0;
  int m_row = 0;
  bit m_err = 0;
  string m_tag = "R9";

  always #4 clk = ~clk;

  seg_page_mapper u0 (.*);

  task automatic chk(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_row(int seg, int pidx, int pl, int ppb, int bpb);
    int r;
    case (pl)
      1: r = seg * ppb + pidx;
      2: r = 2 * seg * ppb + (pidx % 2) * ppb + pidx / 2;
      4: r = 2 * seg * ppb + (pidx % 2) * ppb
             + ((pidx / 2) % 2) * (bpb / 2) * ppb + pidx / 4;
      default: r = 0;
    endcase
    return r % (1 << 24);
  endfunction

  function automatic string tag_of(int pl, int bpb);
    if (pl == 1) return "R1";
    if (pl == 2) return "R2";
    if (pl == 4) return (bpb % 2 == 1) ? "R4" : "R3";
    return "R5";
  endfunction

  task automatic step(bit iv, int seg, int pidx, int pl, int ppb, int bpb, bit rr);
    bit n_valid, n_err;
    int n_row;
    string n_tag;
    req_valid = iv; req_seg = 12'(seg); req_pidx = 9'(pidx);
    cfg_planes = 3'(pl); cfg_ppb = 9'(ppb); cfg_bpb = 14'(bpb); rsp_ready = rr;
    #1;
    chk(req_ready == (!m_valid || rr), "R8 req_ready", int'(req_ready), int'(!m_valid || rr));
    n_valid = m_valid; n_row = m_row; n_err = m_err; n_tag = m_tag;
    if (iv && (!m_valid || rr)) begin
      n_valid = 1; n_row = ref_row(seg, pidx, pl, ppb, bpb);
      n_err = !(pl == 1 || pl == 2 || pl == 4);
      n_tag = tag_of(pl, bpb);
    end else if (rr) begin
      n_valid = 0;
    end else if (m_valid) begin
      n_tag = "R7";
    end
    @(posedge clk); #2;
    m_valid = n_valid; m_row = n_row; m_err = n_err; m_tag = n_tag;
    chk(rsp_valid == m_valid, "R6 rsp_valid", int'(rsp_valid), int'(m_valid));
    if (m_valid && rsp_valid) begin
      chk(int'(rsp_row) == m_row, {m_tag, " rsp_row"}, int'(rsp_row), m_row);
      chk(rsp_err == m_err, {m_tag, " rsp_err"}, int'(rsp_err), int'(m_err));
    end
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    #1;
    chk(rsp_valid == 1'b0, "R9 rsp_valid", int'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R9 req_ready", int'(req_ready), 1);
    // R1: single plane
    step(1, 5, 7, 1, 64, 1024, 1);
    step(1, 4095, 511, 1, 511, 16383, 1);
    // R2: every combination of pidx bit 0
    for (int p = 0; p < 4; p++) step(1, 3, p, 2, 128, 2048, 1);
    // R3: every combination of pidx bits 1:0
    for (int p = 0; p < 8; p++) step(1, 9, p, 4, 64, 1024, 1);
    step(1, 4095, 511, 4, 511, 16383, 1);
    // R4: odd blocks-per-bank
    step(1, 2, 2, 4, 32, 7, 1);
    step(1, 0, 3, 4, 100, 1, 1);
    // R5: every invalid plane code
    step(1, 10, 5, 0, 64, 64, 1);
    step(1, 10, 5, 3, 64, 64, 1);
    step(1, 10, 5, 5, 64, 64, 1);
    step(1, 10, 5, 6, 64, 64, 1);
    step(1, 10, 5, 7, 64, 64, 1);
    // R7: stall with changing request inputs
    step(1, 6, 3, 4, 16, 40, 0);
    step(1, 100, 200, 1, 300, 400, 0);
    step(1, 7, 1, 2, 9, 8, 0);
    step(0, 0, 0, 4, 1, 1, 0);
    // R8: drain and refill back to back, then drain empty
    step(1, 8, 2, 2, 20, 30, 1);
    step(1, 11, 6, 4, 20, 30, 1);
    step(0, 0, 0, 1, 0, 0, 1);
    step(0, 0, 0, 1, 0, 0, 1);
    // random traffic
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, int'($urandom % 4096), int'($urandom % 512),
           int'($urandom % 8), int'($urandom % 512), int'($urandom % 16384),
           ($urandom % 3) != 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule